// File: doc/BRIEF.md
# Armed Single-Frame Camera Capture Engine

This engine stores exactly one frame from a 16-bit parallel pixel bus in external memory. Software programs a base address, the frame width and height and a byte-order select, then pulses `arm`. The engine waits in the pixel clock domain for the next rising edge of `vsync`. From that edge it pairs up valid pixels into 32-bit words. The words cross into the bus clock domain through an asynchronous FIFO. A bus-master port then writes them to consecutive word addresses over a shared Wishbone bus, with no processor involvement.

The pixel side is a valid-only stream. A camera cannot be stalled, so no ready signal goes back to it. `pix_valid` marks each cycle that carries a pixel, and blanking gaps are simply cycles with `pix_valid` low. Back-pressure exists only on the memory side. A Wishbone slave that withholds `wb_ack` holds the current word on the bus and lets the FIFO fill. If a word is pushed while the FIFO is full, it is dropped and a sticky error bit is raised. Once the last word has been acknowledged, `done` rises and stays high until the next accepted arm. The pixel clock (up to 27 MHz) and the bus clock are unrelated.

Top module: `frame_grab_dma`

## Requirements
- R1: `arm` is accepted only while `busy` is low. An arm pulse while `busy` is high changes neither the base address nor the frame size of the capture in progress.
- R2: After an accepted arm, pixels that arrive before the first rising edge of `vsync` are discarded.
- R3: The pixel that arrives with `pix_valid` high in the same pixel clock cycle as the `vsync` rising edge is the first pixel stored, in bits 15:0 of the first word.
- R4: With `swap_bytes` = 0, each word carries the earlier pixel of a pair in bits 15:0 and the later pixel in bits 31:16, and both pixels are unchanged.
- R5: With `swap_bytes` = 1, the half-word positions are the same as in R4, but each pixel has its upper and lower bytes exchanged.
- R6: The first write goes to `base_addr`. Each acknowledged word advances the address by 4.
- R7: Each arm writes exactly `frame_width*frame_height/2` words. Later frames are ignored until the next accepted arm. The width must be even and both sizes nonzero.
- R8: An accepted arm clears `done` and raises `busy`. The acknowledge of the last word drops `busy` and sets `done`, and `done` then holds until the next accepted arm.
- R9: `wb_stb` is high only together with `wb_cyc`, `wb_we` = 1 and `wb_sel` = 4'hF. While a strobe is not acknowledged, the strobe, address and data all hold.
- R10: A word pushed while the FIFO is full sets `overflow_err`, which stays set until reset.
- R11: During and right after reset, `busy`, `done`, `overflow_err` and `wb_cyc` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| arm | input | 1 | One-cycle request to capture the next frame |
| base_addr | input | ADDR_W | Byte address of the first word |
| frame_width | input | WIDTH_W | Pixels per line (even) |
| frame_height | input | HEIGHT_W | Lines per frame |
| swap_bytes | input | 1 | Exchange the two bytes of every pixel |
| busy | output | 1 | Capture armed or in progress |
| done | output | 1 | Last word of the frame acknowledged |
| overflow_err | output | 1 | Sticky FIFO overflow flag |
| pix_clk | input | 1 | Camera pixel clock |
| pix_valid | input | 1 | Pixel present this pixel clock cycle |
| pix_data | input | 16 | Pixel value |
| vsync | input | 1 | Frame sync; its rising edge starts a frame |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | ADDR_W | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The bound checker watches the bus-side rules on every cycle:
- strobe qualification and holding steady through a stalled strobe;
- the 4-byte address step on each acknowledge;
- `done` appearing only on an acknowledge and then holding;
- `overflow_err` never clearing;
- an arm pulse during a capture leaving `busy` untouched.

Whether the right pixels reach memory can only be shown by the bench scenarios. These cover pixels discarded before the sync edge, the first pixel arriving on the edge cycle itself, pair packing in both byte orders, blanking gaps, an ignored second frame, and an ignored re-arm. Each scenario compares every stored word and the word count against values computed from the frame.

// File: rtl/frame_grab_pkg.sv
package frame_grab_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_WAIT,
    CAP_RUN
  } cap_state_t;

  function automatic logic [15:0] order_px(input logic [15:0] px, input logic swap);
    return swap ? {px[7:0], px[15:8]} : px;
  endfunction

endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fg_async_fifo.sv
module fg_async_fifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   rgray_w, wgray_r;
  logic [AW:0]   wbin_nx, rbin_nx;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en && !full) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en && !empty) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  fg_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  fg_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign full  = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign empty = (rgray == wgray_r);
  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/fg_pix_capture.sv
module fg_pix_capture
  import frame_grab_pkg::*;
#(
  parameter int CW = 21
) (
  input  logic          pix_clk,
  input  logic          rst_n,
  input  logic          arm_evt,
  input  logic [CW-1:0] total_words,
  input  logic          swap,
  input  logic          pix_valid,
  input  logic [15:0]   pix_data,
  input  logic          vsync,
  input  logic          fifo_full,
  output logic          push,
  output logic [31:0]   push_word,
  output logic          ovf
);
  cap_state_t    st;
  logic          vsync_q;
  logic          half;
  logic [15:0]   lo;
  logic [CW-1:0] cnt;
  logic          start, take;
  logic [15:0]   px;

  assign px        = order_px(pix_data, swap);
  // Frame start is the cycle vsync is first seen high; its pixel is kept.
  assign start     = (st == CAP_WAIT) && vsync && !vsync_q;
  assign take      = pix_valid && ((st == CAP_RUN) || start);
  assign push      = take && half;
  assign push_word = {px, lo};

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CAP_IDLE;
      vsync_q <= 1'b0;
      half    <= 1'b0;
      lo      <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
    end else begin
      vsync_q <= vsync;
      if (push && fifo_full) ovf <= 1'b1;
      if (arm_evt) begin
        st   <= CAP_WAIT;
        half <= 1'b0;
        cnt  <= '0;
      end else begin
        if (start) st <= CAP_RUN;
        if (take) begin
          half <= !half;
          if (!half) begin
            lo <= px;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == total_words - 1'b1) st <= CAP_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fg_wb_writer.sv
module fg_wb_writer #(
  parameter int ADDR_W = 32,
  parameter int CW     = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CW-1:0]     total,
  input  logic              fifo_empty,
  input  logic [31:0]       fifo_word,
  output logic              pop,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [31:0]       wb_dat_o,
  output logic [3:0]        wb_sel,
  input  logic              wb_ack,
  output logic              busy,
  output logic              done
);
  logic [CW-1:0] remaining;
  logic          accept;

  // Head word is held by the FIFO until popped, so strobe/data stay stable.
  assign wb_stb   = busy && !fifo_empty;
  assign wb_cyc   = wb_stb;
  assign wb_we    = 1'b1;
  assign wb_sel   = 4'hF;
  assign wb_dat_o = fifo_word;
  assign accept   = wb_stb && wb_ack;
  assign pop      = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      wb_adr    <= '0;
      remaining <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      wb_adr    <= base;
      remaining <= total;
    end else if (accept) begin
      wb_adr    <= wb_adr + ADDR_W'(4);
      remaining <= remaining - 1'b1;
      if (remaining == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_grab_dma.sv
module frame_grab_dma
  import frame_grab_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIDTH_W  = 11,
  parameter int HEIGHT_W = 10,
  parameter int FIFO_AW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [WIDTH_W-1:0]  frame_width,
  input  logic [HEIGHT_W-1:0] frame_height,
  input  logic                swap_bytes,
  output logic                busy,
  output logic                done,
  output logic                overflow_err,
  input  logic                pix_clk,
  input  logic                pix_valid,
  input  logic [15:0]         pix_data,
  input  logic                vsync,
  output logic                wb_cyc,
  output logic                wb_stb,
  output logic                wb_we,
  output logic [ADDR_W-1:0]   wb_adr,
  output logic [31:0]         wb_dat_o,
  output logic [3:0]          wb_sel,
  input  logic                wb_ack
);
  localparam int CW = WIDTH_W + HEIGHT_W;

  logic          arm_ok;
  logic [CW-1:0] area, total_now, total_q;
  logic          swap_q, arm_tgl;
  logic          tgl_px, tgl_px_q, arm_evt;
  logic          push, full, pop, empty, ovf_px;
  logic [31:0]   push_word, head_word;

  assign arm_ok    = arm && !busy;
  assign area      = CW'(frame_width) * CW'(frame_height);
  assign total_now = area >> 1;

  // Size and byte order are latched here and stay still while the pixel side runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      swap_q  <= 1'b0;
      arm_tgl <= 1'b0;
    end else if (arm_ok) begin
      total_q <= total_now;
      swap_q  <= swap_bytes;
      arm_tgl <= ~arm_tgl;
    end
  end

  fg_sync #(.W(1)) u_arm_sync (.clk(pix_clk), .rst_n(rst_n), .d(arm_tgl), .q(tgl_px));

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) tgl_px_q <= 1'b0;
    else        tgl_px_q <= tgl_px;
  end
  assign arm_evt = tgl_px ^ tgl_px_q;

  fg_pix_capture #(.CW(CW)) u_cap (
    .pix_clk(pix_clk), .rst_n(rst_n), .arm_evt(arm_evt), .total_words(total_q),
    .swap(swap_q), .pix_valid(pix_valid), .pix_data(pix_data), .vsync(vsync),
    .fifo_full(full), .push(push), .push_word(push_word), .ovf(ovf_px)
  );

  fg_async_fifo #(.DW(32), .AW(FIFO_AW)) u_fifo (
    .wclk(pix_clk), .rst_n(rst_n), .wr_en(push), .wdata(push_word), .full(full),
    .rclk(clk), .rd_en(pop), .rdata(head_word), .empty(empty)
  );

  fg_sync #(.W(1)) u_ovf_sync (.clk(clk), .rst_n(rst_n), .d(ovf_px), .q(overflow_err));

  fg_wb_writer #(.ADDR_W(ADDR_W), .CW(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(arm_ok), .base(base_addr), .total(total_now),
    .fifo_empty(empty), .fifo_word(head_word), .pop(pop),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_ack(wb_ack), .busy(busy), .done(done)
  );
endmodule

// File: rtl/frame_grab_dma_chk.sv
module frame_grab_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              busy,
  input logic              done,
  input logic              overflow_err,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [31:0]       wb_dat_o,
  input logic [3:0]        wb_sel,
  input logic              wb_ack
);
  // R9
  stb_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> (wb_cyc && wb_we && wb_sel == 4'hF));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_dat_o)));

  // R6
  adr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb && wb_ack) |=> (wb_adr == $past(wb_adr) + ADDR_W'(4)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  // R8
  done_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wb_stb && wb_ack));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wb_cyc));

  // R1
  arm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arm && !wb_ack) |=> busy);
endmodule

bind frame_grab_dma frame_grab_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .done(done),
  .overflow_err(overflow_err), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_ack(wb_ack)
);

// File: tb/frame_grab_dma_tb_top.sv
`timescale 1ns/1ps
module frame_grab_dma_tb_top;
  logic        clk = 1'b0, pix_clk = 1'b0, rst_n = 1'b0;
  logic        arm = 1'b0, swap_bytes = 1'b0;
  logic [31:0] base_addr = 32'h0;
  logic [10:0] frame_width = '0;
  logic [9:0]  frame_height = '0;
  logic        pix_valid = 1'b0, vsync = 1'b0;
  logic [15:0] pix_data = '0;
  logic        busy, done, overflow_err;
  logic        wb_cyc, wb_stb, wb_we, wb_ack;
  logic [31:0] wb_adr, wb_dat_o;
  logic [3:0]  wb_sel;

  always #2.5 clk = ~clk;
  always #18  pix_clk = ~pix_clk;

  frame_grab_dma dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .base_addr(base_addr),
    .frame_width(frame_width), .frame_height(frame_height), .swap_bytes(swap_bytes),
    .busy(busy), .done(done), .overflow_err(overflow_err),
    .pix_clk(pix_clk), .pix_valid(pix_valid), .pix_data(pix_data), .vsync(vsync),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_ack(wb_ack)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Memory model: acks after ack_lat wait cycles, records data and checks address order.
  int          ack_lat = 0;
  logic        ack_hold = 1'b0;
  int          wcnt = 0, wr_cnt = 0, addr_err = 0;
  logic [31:0] cur_base = 32'h0;
  logic [31:0] cap [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack <= 1'b0;
      wcnt   <= 0;
    end else begin
      if (wb_stb && wb_ack) begin
        if (wb_adr != cur_base + 32'(wr_cnt * 4) || wr_cnt >= 256) addr_err <= addr_err + 1;
        else cap[wr_cnt] <= wb_dat_o;
        wr_cnt <= wr_cnt + 1;
      end
      if (wb_cyc && wb_stb && !wb_ack && !ack_hold) begin
        if (wcnt >= ack_lat) begin
          wb_ack <= 1'b1;
          wcnt   <= 0;
        end else wcnt <= wcnt + 1;
      end else wb_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pixval(input int seed, input int i);
    return 16'(seed * 7 + i * 259);
  endfunction

  function automatic logic [15:0] sw16(input logic [15:0] x, input bit s);
    return s ? {x[7:0], x[15:8]} : x;
  endfunction

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // Vector table: width, height, swap, ack latency, blanking gaps, junk pixels before sync, re-arm mid-frame
  localparam int NV = 5;
  localparam int VW  [NV] = '{4, 6, 2, 8, 16};
  localparam int VH  [NV] = '{2, 3, 1, 4, 8};
  localparam int VSW [NV] = '{0, 1, 0, 1, 0};
  localparam int VLAT[NV] = '{0, 2, 1, 3, 0};
  localparam int VGAP[NV] = '{0, 0, 1, 0, 1};
  localparam int VPRE[NV] = '{0, 3, 2, 5, 1};
  localparam int VRE [NV] = '{0, 1, 0, 0, 1};

  task automatic run_vec(input int v);
    int n, words, seed, tmo;
    logic [31:0] exp;
    n     = VW[v] * VH[v];
    words = n / 2;
    seed  = 100 + v * 13;
    frame_width  = 11'(VW[v]);
    frame_height = 10'(VH[v]);
    swap_bytes   = VSW[v][0];
    ack_lat      = VLAT[v];
    base_addr    = 32'h1000_0000 + 32'(v * 32'h400);
    cur_base     = base_addr;
    @(negedge clk);
    wr_cnt = 0; addr_err = 0;
    pulse_arm();
    @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R8 busy/done after arm", {30'd0, busy, done}, 32'h2);
    repeat (8) @(negedge pix_clk);
    for (int k = 0; k < VPRE[v]; k++) begin
      @(negedge pix_clk); vsync = 1'b0; pix_valid = 1'b1; pix_data = 16'hDEAD;
    end
    for (int i = 0; i < n; i++) begin
      if (VGAP[v] != 0 && i % 3 == 2) begin
        @(negedge pix_clk); pix_valid = 1'b0;
      end
      @(negedge pix_clk); vsync = 1'b1; pix_valid = 1'b1; pix_data = pixval(seed, i);
      if (VRE[v] != 0 && i == n / 2) begin
        base_addr = 32'h7000_0000;
        frame_width = 11'd2; frame_height = 10'd1;
        pulse_arm();
        base_addr = cur_base;
      end
    end
    @(negedge pix_clk); pix_valid = 1'b0; vsync = 1'b0;
    repeat (4) @(negedge pix_clk);
    for (int i = 0; i < n; i++) begin
      @(negedge pix_clk); vsync = 1'b1; pix_valid = 1'b1; pix_data = pixval(seed + 1, i) ^ 16'hFFFF;
    end
    @(negedge pix_clk); pix_valid = 1'b0; vsync = 1'b0;
    tmo = 0;
    while (!done && tmo < 20000) begin @(negedge clk); tmo++; end
    repeat (40) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R8 done after last ack", {30'd0, busy, done}, 32'h1);
    check(wr_cnt == words, "R7 word count per arm", 32'(wr_cnt), 32'(words));
    check(addr_err == 0, "R6 R1 address sequence from base", 32'(addr_err), 32'h0);
    check(overflow_err == 1'b0, "R10 no overflow in normal run", {31'd0, overflow_err}, 32'h0);
    for (int w = 0; w < words && w < 256; w++) begin
      exp = {sw16(pixval(seed, 2*w+1), VSW[v][0]), sw16(pixval(seed, 2*w), VSW[v][0])};
      if (w == 0) check(cap[0][15:0] == exp[15:0], "R2 R3 first pixel of frame", {16'd0, cap[0][15:0]}, {16'd0, exp[15:0]});
      if (VSW[v] != 0) check(cap[w] == exp, "R5 swapped packing", cap[w], exp);
      else             check(cap[w] == exp, "R4 pair packing", cap[w], exp);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && overflow_err == 1'b0 && wb_cyc == 1'b0,
          "R11 state in reset", {28'd0, busy, done, overflow_err, wb_cyc}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge pix_clk);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && wb_cyc == 1'b0, "R11 state after reset",
          {29'd0, busy, done, wb_cyc}, 32'h0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // Overflow: memory stalls forever while 64 words arrive.
    ack_hold = 1'b1;
    frame_width = 11'd16; frame_height = 10'd8; swap_bytes = 1'b0;
    base_addr = 32'h2000_0000; cur_base = base_addr;
    pulse_arm();
    repeat (8) @(negedge pix_clk);
    for (int i = 0; i < 128; i++) begin
      @(negedge pix_clk); vsync = 1'b1; pix_valid = 1'b1; pix_data = pixval(9, i);
    end
    @(negedge pix_clk); pix_valid = 1'b0; vsync = 1'b0;
    repeat (10) @(negedge pix_clk);
    @(negedge clk);
    check(overflow_err == 1'b1, "R10 overflow raised", {31'd0, overflow_err}, 32'h1);
    check(done == 1'b0 && busy == 1'b1, "R8 no done while stalled", {30'd0, busy, done}, 32'h2);
    repeat (300) @(negedge clk);
    check(overflow_err == 1'b1, "R10 overflow sticky", {31'd0, overflow_err}, 32'h1);
    rst_n = 1'b0;
    ack_hold = 1'b0;
    repeat (3) @(negedge clk);
    check(overflow_err == 1'b0 && busy == 1'b0 && done == 1'b0 && wb_cyc == 1'b0,
          "R11 reset clears error", {28'd0, busy, done, overflow_err, wb_cyc}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=%0h expected=%0h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule